// File: doc/BRIEF.md
# SDRAM Controller Control/Status Register File

This block holds the control and status registers of an SDRAM controller. Software reaches them through two numbers on a simple device-control-register bus. One number holds an offset pointer. The other is a data window that reads or writes the register the pointer selects. Reads return data in the same cycle as the read strobe. A write takes effect on the clock edge at which the write strobe is high.

The register file drives several outputs: the global controller enable, one configuration word per memory bank for the address-window decoder, and the refresh and timing words. It also drives a level interrupt that stays high while the ECC error status holds any set bit. The two bus-error status registers are filled only through a test load port. Software clears their bits by writing ones.

Top module: `sdc_csr_file`

## Requirements
- R1: A write to bus number 0x010 stores the full 32-bit offset pointer, and a read of 0x010 returns it. Reads and writes at bus number 0x011 act on the register at the stored offset. A read of any other bus number, or any read with the read strobe low, returns 0.
- R2: After reset, the data window reads back as follows: configuration (offset 0x20) is 0x00800000, refresh (0x30) is 0x05F00000, power management (0x34) is 0x07C00000, and every other stored register is 0. The timing output word is 0x00854009, the pointer is 0 and the interrupt is low.
- R3: Each error status register (offsets 0x00 and 0x08) clears every bit that a data-window write sets to 1. A test load of either register replaces its contents, and a test load wins over a bus write in the same cycle.
- R4: The status register at offset 0x24 keeps its value across data-window writes to it.
- R5: A configuration write stores the value ANDed with 0xFFE00000, and bit 31 is the enable output. When bit 31 goes from 0 to 1, status bit 31 clears. When it goes from 1 to 0, status bit 31 sets.
- R6: Status bit 30 sets when configuration bit 30 goes from 0 to 1 and clears when it goes from 1 to 0.
- R7: Writes store the value ANDed with a mask. The masks are 0x3FF80000 for refresh (0x30), 0x018FC01F for timing (0x80), 0x00F00000 for ECC configuration (0x94) and 0xFFF0F000 for ECC error status (0x98). The error address register (0x10) stores all 32 bits. Power management (0x34) stores (value AND 0xF8000000) OR 0x07C00000.
- R8: Offset 0x80 reads as 0xFFFFFFFF, although the timing output shows the stored value. Any offset outside the map reads 0xFFFFFFFF, and writes to it change no register.
- R9: The interrupt output goes high after a write leaves the ECC error status non-zero. It goes low after a write leaves it zero.
- R10: Bank i's configuration is at offset 0x40+4*i. A write to it stores the value ANDed with 0xFFDEE001, but only when bit i of the FITTED parameter is set. An unfitted bank stays 0 on the bus and on its output.
- R11: A value written through the data window is visible to a read in the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | SEL_W | Device-control bus register number |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| tst_load_es0 | input | 1 | Test load of error status 0 |
| tst_load_es1 | input | 1 | Test load of error status 1 |
| tst_err_data | input | 32 | Test load value |
| mc_enable | output | 1 | Global controller enable |
| bank_cfg | output | 32*NBANK | Bank configuration words, bank 0 in the low bits |
| refresh_word | output | 32 | Refresh register |
| timing_word | output | 32 | Timing register |
| ecc_irq | output | 1 | Level ECC error interrupt |

## Verification
Two effects are hard to provoke from the ports: the enable edges in the status register, and an ECC error write whose set bits all fall outside the mask. For the enable edges, the bench sweeps every byte offset with alternating all-ones, all-zeros and checkerboard patterns, so configuration bit 31 and bit 30 rise and fall in turn. For the masked-out case, the bench writes ECC error values whose only set bits lie outside the mask and confirms the interrupt stays low. The bank bus is built with one bank unfitted, so writes to that bank must be dropped.

// File: rtl/sdc_csr_pkg.sv
package sdc_csr_pkg;
  typedef logic [31:0] word_t;

  localparam word_t OFS_ERRST0 = 32'h00;
  localparam word_t OFS_ERRST1 = 32'h08;
  localparam word_t OFS_ERRADR = 32'h10;
  localparam word_t OFS_CFG    = 32'h20;
  localparam word_t OFS_STAT   = 32'h24;
  localparam word_t OFS_RFSH   = 32'h30;
  localparam word_t OFS_PWR    = 32'h34;
  localparam word_t OFS_BANK0  = 32'h40;
  localparam word_t OFS_TIM    = 32'h80;
  localparam word_t OFS_ECCCFG = 32'h94;
  localparam word_t OFS_ECCERR = 32'h98;

  localparam word_t MSK_CFG    = 32'hFFE0_0000;
  localparam word_t MSK_RFSH   = 32'h3FF8_0000;
  localparam word_t MSK_PWR    = 32'hF800_0000;
  localparam word_t SET_PWR    = 32'h07C0_0000;
  localparam word_t MSK_TIM    = 32'h018F_C01F;
  localparam word_t MSK_ECCCFG = 32'h00F0_0000;
  localparam word_t MSK_ECCERR = 32'hFFF0_F000;
  localparam word_t MSK_BANK   = 32'hFFDE_E001;

  localparam word_t RST_CFG    = 32'h0080_0000;
  localparam word_t RST_RFSH   = 32'h05F0_0000;
  localparam word_t RST_PWR    = 32'h07C0_0000;
  localparam word_t RST_TIM    = 32'h0085_4009;

  localparam int EN_BIT  = 31;
  localparam int SR_BIT  = 30;

  typedef struct packed {
    logic es0;
    logic es1;
    logic eadr;
    logic cfg;
    logic stat;
    logic rfsh;
    logic pwr;
    logic tim;
    logic ecccfg;
    logic eccerr;
  } hit_t;
endpackage

// File: rtl/sdc_csr_decode.sv
module sdc_csr_decode
  import sdc_csr_pkg::*;
#(
  parameter int NBANK = 4
) (
  input  word_t             offset,
  output hit_t              hit,
  output logic [NBANK-1:0]  bank_hit,
  output logic              mapped
);
  always_comb begin
    hit.es0    = (offset == OFS_ERRST0);
    hit.es1    = (offset == OFS_ERRST1);
    hit.eadr   = (offset == OFS_ERRADR);
    hit.cfg    = (offset == OFS_CFG);
    hit.stat   = (offset == OFS_STAT);
    hit.rfsh   = (offset == OFS_RFSH);
    hit.pwr    = (offset == OFS_PWR);
    hit.tim    = (offset == OFS_TIM);
    hit.ecccfg = (offset == OFS_ECCCFG);
    hit.eccerr = (offset == OFS_ECCERR);
  end

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    assign bank_hit[i] = (offset == OFS_BANK0 + 32'(4 * i));
  end

  assign mapped = (|hit) | (|bank_hit);
endmodule

// File: rtl/sdc_bank_regs.sv
module sdc_bank_regs
  import sdc_csr_pkg::*;
#(
  parameter int               NBANK  = 4,
  parameter logic [NBANK-1:0] FITTED = '1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [NBANK-1:0]    bank_hit,
  input  word_t               wdata,
  output logic [32*NBANK-1:0] words
);
  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    if (FITTED[i]) begin : g_fit
      word_t q;
      always_ff @(posedge clk) begin
        if (rst)                   q <= '0;
        else if (we && bank_hit[i]) q <= wdata & MSK_BANK;
      end
      assign words[32*i +: 32] = q;
    end else begin : g_empty
      assign words[32*i +: 32] = '0;
    end
  end
endmodule

// File: rtl/sdc_cfg_status.sv
module sdc_cfg_status
  import sdc_csr_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  we,
  input  word_t wdata,
  output word_t cfg_q,
  output word_t stat_q
);
  word_t cfg_n;
  assign cfg_n = wdata & MSK_CFG;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= RST_CFG;
      stat_q <= '0;
    end else if (we) begin
      cfg_q <= cfg_n;
      if (!cfg_q[EN_BIT] && cfg_n[EN_BIT])      stat_q[EN_BIT] <= 1'b0;
      else if (cfg_q[EN_BIT] && !cfg_n[EN_BIT]) stat_q[EN_BIT] <= 1'b1;
      if (!cfg_q[SR_BIT] && cfg_n[SR_BIT])      stat_q[SR_BIT] <= 1'b1;
      else if (cfg_q[SR_BIT] && !cfg_n[SR_BIT]) stat_q[SR_BIT] <= 1'b0;
    end
  end
endmodule

// File: rtl/sdc_csr_file.sv
module sdc_csr_file
  import sdc_csr_pkg::*;
#(
  parameter int               SEL_W     = 10,
  parameter logic [SEL_W-1:0] ADDR_PORT = 10'h010,
  parameter logic [SEL_W-1:0] DATA_PORT = 10'h011,
  parameter int               NBANK     = 4,
  parameter logic [NBANK-1:0] FITTED    = '1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SEL_W-1:0]    bus_sel,
  input  logic                bus_rd,
  input  logic                bus_wr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic                tst_load_es0,
  input  logic                tst_load_es1,
  input  logic [31:0]         tst_err_data,
  output logic                mc_enable,
  output logic [32*NBANK-1:0] bank_cfg,
  output logic [31:0]         refresh_word,
  output logic [31:0]         timing_word,
  output logic                ecc_irq
);
  word_t off_q, es0_q, es1_q, eadr_q, rfsh_q, pwr_q, tim_q, ecccfg_q, eccerr_q;
  word_t cfg_q, stat_q, eccerr_n;
  hit_t              hit;
  logic [NBANK-1:0]  bank_hit;
  logic              mapped;
  logic              wr_ptr, wr_win;

  assign wr_ptr   = bus_wr && (bus_sel == ADDR_PORT);
  assign wr_win   = bus_wr && (bus_sel == DATA_PORT);
  assign eccerr_n = bus_wdata & MSK_ECCERR;

  sdc_csr_decode #(.NBANK(NBANK)) u_dec (
    .offset(off_q), .hit(hit), .bank_hit(bank_hit), .mapped(mapped)
  );

  sdc_cfg_status u_cfg (
    .clk(clk), .rst(rst), .we(wr_win && hit.cfg), .wdata(bus_wdata),
    .cfg_q(cfg_q), .stat_q(stat_q)
  );

  sdc_bank_regs #(.NBANK(NBANK), .FITTED(FITTED)) u_bank (
    .clk(clk), .rst(rst), .we(wr_win), .bank_hit(bank_hit),
    .wdata(bus_wdata), .words(bank_cfg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q    <= '0;
      es0_q    <= '0;
      es1_q    <= '0;
      eadr_q   <= '0;
      rfsh_q   <= RST_RFSH;
      pwr_q    <= RST_PWR;
      tim_q    <= RST_TIM;
      ecccfg_q <= '0;
      eccerr_q <= '0;
      ecc_irq  <= 1'b0;
    end else begin
      if (wr_ptr) off_q <= bus_wdata;
      if (tst_load_es0)             es0_q <= tst_err_data;
      else if (wr_win && hit.es0)   es0_q <= es0_q & ~bus_wdata;
      if (tst_load_es1)             es1_q <= tst_err_data;
      else if (wr_win && hit.es1)   es1_q <= es1_q & ~bus_wdata;
      if (wr_win) begin
        if (hit.eadr)   eadr_q   <= bus_wdata;
        if (hit.rfsh)   rfsh_q   <= bus_wdata & MSK_RFSH;
        if (hit.pwr)    pwr_q    <= (bus_wdata & MSK_PWR) | SET_PWR;
        if (hit.tim)    tim_q    <= bus_wdata & MSK_TIM;
        if (hit.ecccfg) ecccfg_q <= bus_wdata & MSK_ECCCFG;
        if (hit.eccerr) begin
          eccerr_q <= eccerr_n;
          ecc_irq  <= (eccerr_n != '0);
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_sel == ADDR_PORT) begin
        bus_rdata = off_q;
      end else if (bus_sel == DATA_PORT) begin
        bus_rdata = '1;
        if (hit.es0)    bus_rdata = es0_q;
        if (hit.es1)    bus_rdata = es1_q;
        if (hit.eadr)   bus_rdata = eadr_q;
        if (hit.cfg)    bus_rdata = cfg_q;
        if (hit.stat)   bus_rdata = stat_q;
        if (hit.rfsh)   bus_rdata = rfsh_q;
        if (hit.pwr)    bus_rdata = pwr_q;
        if (hit.ecccfg) bus_rdata = ecccfg_q;
        if (hit.eccerr) bus_rdata = eccerr_q;
        for (int i = 0; i < NBANK; i++)
          if (bank_hit[i]) bus_rdata = bank_cfg[32*i +: 32];
        if (!mapped || hit.tim) bus_rdata = '1;
      end
    end
  end

  assign mc_enable    = cfg_q[EN_BIT];
  assign refresh_word = rfsh_q;
  assign timing_word  = tim_q;
endmodule

// File: rtl/sdc_csr_checker.sv
module sdc_csr_checker
  import sdc_csr_pkg::*;
#(
  parameter int               SEL_W     = 10,
  parameter logic [SEL_W-1:0] ADDR_PORT = 10'h010,
  parameter logic [SEL_W-1:0] DATA_PORT = 10'h011,
  parameter int               NBANK     = 4,
  parameter logic [NBANK-1:0] FITTED    = '1
) (
  input logic                clk,
  input logic                rst,
  input logic [SEL_W-1:0]    bus_sel,
  input logic                bus_rd,
  input logic                bus_wr,
  input logic [31:0]         bus_wdata,
  input logic [31:0]         bus_rdata,
  input logic                mc_enable,
  input logic [32*NBANK-1:0] bank_cfg,
  input logic                ecc_irq,
  input word_t               off_q,
  input word_t               stat_q
);
  logic [32*NBANK-1:0] allowed;
  always_comb
    for (int i = 0; i < NBANK; i++)
      allowed[32*i +: 32] = FITTED[i] ? MSK_BANK : '0;

  logic win_wr;
  assign win_wr = bus_wr && (bus_sel == DATA_PORT);

  assert_ptr_read_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_sel == ADDR_PORT) |-> (bus_rdata == off_q));

  assert_status_ro_R4: assert property (@(posedge clk) disable iff (rst)
    (win_wr && off_q == OFS_STAT) |=> $stable(stat_q));

  assert_enable_rise_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(mc_enable) |-> !stat_q[EN_BIT]);

  assert_enable_fall_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(mc_enable) |-> stat_q[EN_BIT]);

  assert_timing_ones_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_sel == DATA_PORT && off_q == OFS_TIM) |-> (bus_rdata == '1));

  assert_irq_set_R9: assert property (@(posedge clk) disable iff (rst)
    (win_wr && off_q == OFS_ECCERR && (bus_wdata & MSK_ECCERR) != '0) |=> ecc_irq);

  assert_irq_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (win_wr && off_q == OFS_ECCERR && (bus_wdata & MSK_ECCERR) == '0) |=> !ecc_irq);

  assert_bank_mask_R10: assert property (@(posedge clk) disable iff (rst)
    ((bank_cfg & ~allowed) == '0));
endmodule

bind sdc_csr_file sdc_csr_checker #(
  .SEL_W(SEL_W), .ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT),
  .NBANK(NBANK), .FITTED(FITTED)
) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mc_enable(mc_enable),
  .bank_cfg(bank_cfg), .ecc_irq(ecc_irq), .off_q(off_q), .stat_q(stat_q)
);

// File: tb/sdc_csr_file_test.sv
module sdc_csr_file_test;
  localparam int         NB  = 4;
  localparam logic [3:0] FIT = 4'b1011;
  localparam logic [9:0] AP  = 10'h010;
  localparam logic [9:0] DP  = 10'h011;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  bus_sel = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        tst_load_es0 = 1'b0, tst_load_es1 = 1'b0;
  logic [31:0] tst_err_data = '0;
  logic        mc_enable, ecc_irq;
  logic [127:0] bank_cfg;
  logic [31:0] refresh_word, timing_word;

  int n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  sdc_csr_file #(.NBANK(NB), .FITTED(FIT)) uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tst_load_es0(tst_load_es0),
    .tst_load_es1(tst_load_es1), .tst_err_data(tst_err_data),
    .mc_enable(mc_enable), .bank_cfg(bank_cfg), .refresh_word(refresh_word),
    .timing_word(timing_word), .ecc_irq(ecc_irq)
  );

  // bench model
  logic [31:0] m_ptr, m_es0, m_es1, m_ea, m_cfg, m_st, m_rf, m_pm, m_tr, m_ec, m_ee;
  logic [31:0] m_bk [4];
  logic        m_irq;

  task automatic model_reset();
    m_ptr = 0; m_es0 = 0; m_es1 = 0; m_ea = 0; m_cfg = 32'h0080_0000; m_st = 0;
    m_rf = 32'h05F0_0000; m_pm = 32'h07C0_0000; m_tr = 32'h0085_4009;
    m_ec = 0; m_ee = 0; m_irq = 0;
    for (int i = 0; i < 4; i++) m_bk[i] = 0;
  endtask

  function automatic logic [31:0] model_read(input logic [31:0] o);
    logic [31:0] r = 32'hFFFF_FFFF;
    case (o)
      32'h00: r = m_es0;
      32'h08: r = m_es1;
      32'h10: r = m_ea;
      32'h20: r = m_cfg;
      32'h24: r = m_st;
      32'h30: r = m_rf;
      32'h34: r = m_pm;
      32'h40: r = m_bk[0];
      32'h44: r = m_bk[1];
      32'h48: r = m_bk[2];
      32'h4C: r = m_bk[3];
      32'h94: r = m_ec;
      32'h98: r = m_ee;
      default: r = 32'hFFFF_FFFF;
    endcase
    return r;
  endfunction

  task automatic model_write(input logic [31:0] o, input logic [31:0] v);
    logic [31:0] nv;
    case (o)
      32'h00: m_es0 &= ~v;
      32'h08: m_es1 &= ~v;
      32'h10: m_ea = v;
      32'h20: begin
        nv = v & 32'hFFE0_0000;
        if (!m_cfg[31] && nv[31]) m_st[31] = 0;
        else if (m_cfg[31] && !nv[31]) m_st[31] = 1;
        if (!m_cfg[30] && nv[30]) m_st[30] = 1;
        else if (m_cfg[30] && !nv[30]) m_st[30] = 0;
        m_cfg = nv;
      end
      32'h30: m_rf = v & 32'h3FF8_0000;
      32'h34: m_pm = (v & 32'hF800_0000) | 32'h07C0_0000;
      32'h40, 32'h44, 32'h48, 32'h4C:
        if (FIT[(o - 32'h40) >> 2]) m_bk[(o - 32'h40) >> 2] = v & 32'hFFDE_E001;
      32'h80: m_tr = v & 32'h018F_C01F;
      32'h94: m_ec = v & 32'h00F0_0000;
      32'h98: begin m_ee = v & 32'hFFF0_F000; m_irq = (m_ee != 0); end
      default: ;
    endcase
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [9:0] s, input logic [31:0] d);
    @(negedge clk);
    bus_sel = s; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [9:0] s, output logic [31:0] d);
    @(negedge clk);
    bus_sel = s; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic win_write(input logic [31:0] o, input logic [31:0] v);
    bus_write(AP, o); m_ptr = o;
    bus_write(DP, v); model_write(o, v);
  endtask

  task automatic win_check(input logic [31:0] o, input string req);
    logic [31:0] r;
    bus_write(AP, o); m_ptr = o;
    bus_read(DP, r);
    check(req, r, model_read(o));
  endtask

  task automatic check_outputs(input string req);
    check({req, " enable"}, {31'd0, mc_enable}, {31'd0, m_cfg[31]});
    check({req, " refresh"}, refresh_word, m_rf);
    check({req, " timing"}, timing_word, m_tr);
    check({req, " irq"}, {31'd0, ecc_irq}, {31'd0, m_irq});
    for (int i = 0; i < 4; i++) check({req, " bank R10"}, bank_cfg[32*i +: 32], m_bk[i]);
  endtask

  task automatic test_load(input logic which, input logic [31:0] v);
    @(negedge clk);
    tst_err_data = v;
    if (which) tst_load_es1 = 1'b1; else tst_load_es0 = 1'b1;
    @(negedge clk);
    tst_load_es0 = 1'b0; tst_load_es1 = 1'b0;
    if (which) m_es1 = v; else m_es0 = v;
  endtask

  initial begin
    #400000;
    n_err++; n_chk++;
    $display("FAIL watchdog: got hang expected finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [31:0] pats [6];
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0000_0000; pats[2] = 32'hA5A5_A5A5;
    pats[3] = 32'h5A5A_5A5A; pats[4] = 32'hFFFF_FFFF; pats[5] = 32'h0000_0000;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R2 reset state over every byte offset
    check_outputs("R2 reset");
    bus_read(AP, r); check("R2 pointer", r, 32'h0);
    for (int o = 0; o < 256; o++) win_check(o, "R2 R8 reset read");

    // R1 pointer and foreign bus numbers
    bus_write(AP, 32'hDEAD_0124); bus_read(AP, r); check("R1 pointer", r, 32'hDEAD_0124);
    bus_read(10'h012, r); check("R1 other number", r, 32'h0);
    bus_read(10'h3FF, r); check("R1 other number", r, 32'h0);
    @(negedge clk); bus_sel = AP; #1 check("R1 no strobe", bus_rdata, 32'h0);
    win_check(32'h0000_0120, "R1 R8 wide offset");

    // Sweep: all offsets with several patterns, W1C after test loads
    foreach (pats[p]) begin
      test_load(0, 32'hFFFF_FFFF);
      test_load(1, 32'h1234_8765);
      for (int o = 0; o < 256; o++) begin
        win_write(o, pats[p]);
        if (o == 32'h98) check("R9 irq after write", {31'd0, ecc_irq}, {31'd0, m_irq});
        if (o == 32'h20) check("R5 R6 status after cfg", model_read(32'h24), m_st);
      end
      for (int o = 0; o < 256; o++) win_check(o, "R3 R4 R5 R6 R7 R8 R10 sweep");
      check_outputs("R5 R7 sweep");
    end

    // R11: readback right after write
    win_write(32'h30, 32'hFFFF_FFFF); win_check(32'h30, "R11 R7 refresh");
    win_write(32'h10, 32'h0BAD_F00D); win_check(32'h10, "R11 R7 erradr");

    // R5/R6 explicit edges
    win_write(32'h20, 32'h8000_0000); win_check(32'h24, "R5 enable rise");
    check("R5 enable out", {31'd0, mc_enable}, 32'd1);
    win_write(32'h20, 32'h4000_0000); win_check(32'h24, "R5 R6 fall + sr rise");
    win_write(32'h20, 32'h0000_0000); win_check(32'h24, "R6 sr fall");
    win_write(32'h24, 32'h0000_0000); win_check(32'h24, "R4 status ro");

    // R9 masked-out values keep irq low
    win_write(32'h98, 32'h0000_0000); check("R9 clear", {31'd0, ecc_irq}, 32'd0);
    win_write(32'h98, 32'h000F_0FFF); check("R9 masked", {31'd0, ecc_irq}, 32'd0);
    win_write(32'h98, 32'h0000_1000); check("R9 set", {31'd0, ecc_irq}, 32'd1);
    win_write(32'h98, 32'h0000_2000); check("R9 stays", {31'd0, ecc_irq}, 32'd1);
    win_write(32'h98, 32'h000F_0000); check("R9 drop", {31'd0, ecc_irq}, 32'd0);

    // R3 test load beats same-cycle W1C
    bus_write(AP, 32'h00); m_ptr = 0;
    @(negedge clk);
    bus_sel = DP; bus_wdata = 32'hFFFF_FFFF; bus_wr = 1'b1;
    tst_err_data = 32'hCAFE_0001; tst_load_es0 = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tst_load_es0 = 1'b0; m_es0 = 32'hCAFE_0001;
    win_check(32'h00, "R3 load priority");
    win_write(32'h00, 32'h0000_0001); win_check(32'h00, "R3 w1c");

    // R10 unfitted bank 2
    win_write(32'h48, 32'hFFFF_FFFF); win_check(32'h48, "R10 unfitted");
    check("R10 unfitted out", bank_cfg[64 +: 32], 32'h0);
    win_write(32'h4C, 32'hFFFF_FFFF); check("R10 fitted out", bank_cfg[96 +: 32], 32'hFFDE_E001);

    // R2 reset again
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0; model_reset();
    check_outputs("R2 re-reset");
    win_check(32'h20, "R2 cfg"); win_check(32'h34, "R2 pwr");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule